// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block is the device-side receive engine for one non-isochronous OUT endpoint: control data stages, bulk or interrupt. A packet decoder upstream reports OUT tokens, the data PID at the start of each data packet, the payload bytes and an end-of-packet strobe with the CRC result. For each token the controller decides whether the packet may enter a small receive FIFO. At the end of the data packet it reports the handshake to return. It keeps the endpoint's remaining transfer size and packet count. A drain stage then moves the committed FIFO words to memory through a simple word-write port.

Software arms the endpoint with a transfer size, a packet count and a word-aligned buffer address. The size must be n times the maximum packet size rounded up to a whole number of 32-bit words, and the count must be n, with n > 0. Every packet starts on a word boundary in memory. Bytes are packed little-endian and any unused lanes of a packet's last word are written as zero. A packet leaves data behind only if it completes with a good CRC and carries the expected data toggle. Failed or repeated packets are rolled back by rewinding a tentative FIFO pointer. The transfer ends when the count runs out or a short packet arrives. At that point the endpoint disables itself and sets NAK.

Top module: `usb_out_ep_rx`

## Requirements
- R1: After reset the endpoint is disabled, NAK is set, and size and count read zero. An `arm` pulse loads `arm_size`, `arm_count` and `arm_base`, sets `ep_enabled` and clears `ep_nak`.
- R2: An OUT token that arrives while the endpoint is disabled or NAK is set is answered with NAK at the end of its data packet. Nothing is written and size and count do not change.
- R3: A token is admitted only when the FIFO has at least ceil(mps/4) free words, counted from the committed pointer. Otherwise the data packet that follows is answered with NAK and not stored.
- R4: An admitted packet with a good CRC and the expected PID is committed and ACKed, and the count drops by 1. The size drops by the bytes the packet occupies: the payload length for a short packet, or mps rounded up to a multiple of 4 for a full one.
- R5: A good packet whose PID differs from the expected toggle is a retransmission. It is ACKed but discarded, and size, count and toggle are unchanged.
- R6: A packet that ends with a bad CRC gets no handshake, leaves no data and changes no counter.
- R7: A packet with more than mps payload bytes gets no handshake and is discarded.
- R8: Packets are stored from `arm_base` on consecutive word addresses, each starting on a new word. The first payload byte goes to bits 7:0 and unused lanes of a packet's last word are zero.
- R9: The transfer completes on the packet that brings the count to zero or on any short packet (length < mps). `xfer_done` pulses with the ACK, `ep_enabled` clears and `ep_nak` sets.
- R10: `hs_valid` pulses for one cycle in the cycle after `rx_eop`; `hs_ack` is 1 for ACK and 0 for NAK.
- R11: `mem_we` holds a word until `mem_ready`; the address advances by 4 only on an accepted write.
- R12: The expected toggle starts at DATA0 after reset (`pkt_pid` 0 = DATA0, 1 = DATA1) and flips on every committed packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mps | input | 11 | Maximum packet size in bytes (nonzero) |
| arm | input | 1 | Pulse: load transfer and enable endpoint |
| arm_size | input | 19 | Transfer size in bytes |
| arm_count | input | 10 | Packet count |
| arm_base | input | 32 | Word-aligned buffer byte address |
| tok_out | input | 1 | OUT token addressed to this endpoint |
| pkt_start | input | 1 | Start of data packet, PID valid |
| pkt_pid | input | 1 | Data PID: 0 DATA0, 1 DATA1 |
| rx_valid | input | 1 | Payload byte valid |
| rx_byte | input | 8 | Payload byte |
| rx_eop | input | 1 | End of data packet (never with rx_valid) |
| rx_crc_ok | input | 1 | Data CRC good, valid with rx_eop |
| hs_valid | output | 1 | Handshake to send |
| hs_ack | output | 1 | 1 ACK, 0 NAK |
| ep_enabled | output | 1 | Endpoint enabled |
| ep_nak | output | 1 | Endpoint NAK state |
| xfer_size | output | 19 | Remaining transfer size |
| pkt_count | output | 10 | Remaining packet count |
| xfer_done | output | 1 | Transfer-complete pulse |
| mem_ready | input | 1 | Memory accepts a word |
| mem_we | output | 1 | Word write request |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Word data |

## Verification
The bench repeats an accepted DATA0 packet. A design that counted retransmissions would lower the count and write a second copy to memory. It follows with bad-CRC and oversized packets. Failing to rewind the tentative pointer would leave their bytes in memory and shift the addresses of later packets. It then stalls the memory port until the FIFO has less free room than one packet. A design that admitted anyway would overwrite undrained words instead of answering NAK. A short packet ending the transfer before the count runs out exposes a controller that only watches the count, and the zero lanes checked in padded words catch a packer that reuses stale bytes.

// File: rtl/usbrx_pkg.sv
`timescale 1ns/1ps
package usbrx_pkg;
  // receive phase between an OUT token and the end of its data packet
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_TAKE   = 2'd1,
    MODE_REFUSE = 2'd2
  } rx_mode_e;
endpackage

// File: rtl/usbrx_packer.sv
`timescale 1ns/1ps
module usbrx_packer #(
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_eop,
  input  logic [MPS_W-1:0] cfg_mps,
  output logic             wr_en,
  output logic [31:0]      wr_data,
  output logic [MPS_W:0]   pkt_len,
  output logic             babble
);
  localparam int LEN_W = MPS_W + 1;

  logic [1:0]       lane_q, lane_d;
  logic [23:0]      hold_q, hold_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] mps_ext;
  logic             byte_ok, flush;

  assign mps_ext = LEN_W'(cfg_mps);
  assign byte_ok = take && rx_valid && (len_q < mps_ext);
  assign flush   = take && rx_eop && (lane_q != 2'd0);
  assign wr_en   = (byte_ok && (lane_q == 2'd3)) || flush;
  assign wr_data = byte_ok ? {rx_byte, hold_q} : {8'h00, hold_q};
  assign pkt_len = len_q;
  assign babble  = len_q > mps_ext;

  always_comb begin
    lane_d = lane_q;
    hold_d = hold_q;
    len_d  = len_q;
    if (rx_eop) begin
      lane_d = 2'd0;
      hold_d = '0;
      len_d  = '0;
    end else begin
      if (byte_ok) begin
        lane_d = lane_q + 2'd1;
        case (lane_q)
          2'd0:    hold_d[7:0]   = rx_byte;
          2'd1:    hold_d[15:8]  = rx_byte;
          2'd2:    hold_d[23:16] = rx_byte;
          default: hold_d        = '0;
        endcase
      end
      if (take && rx_valid && (len_q <= mps_ext)) begin
        len_d = len_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      hold_q <= '0;
      len_q  <= '0;
    end else begin
      lane_q <= lane_d;
      hold_q <= hold_d;
      len_q  <= len_d;
    end
  end
endmodule

// File: rtl/usbrx_fifo.sv
`timescale 1ns/1ps
module usbrx_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  input  logic                     commit,
  input  logic                     rewind,
  input  logic                     rd_en,
  output logic                     rd_valid,
  output logic [31:0]              rd_data,
  output logic [$clog2(DEPTH):0]   free_words
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [31:0]   store_q [DEPTH];
  logic [PW-1:0] tent_q, tent_d, done_q, done_d, rd_q, rd_d;
  logic [PW-1:0] tent_inc;

  assign tent_inc   = wr_en ? tent_q + 1'b1 : tent_q;
  assign rd_valid   = rd_q != done_q;
  assign rd_data    = store_q[rd_q[AW-1:0]];
  assign free_words = PW'(DEPTH) - (done_q - rd_q);

  always_comb begin
    tent_d = rewind ? done_q : tent_inc;
    done_d = commit ? tent_inc : done_q;
    rd_d   = (rd_en && rd_valid) ? rd_q + 1'b1 : rd_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[tent_q[AW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tent_q <= '0;
      done_q <= '0;
      rd_q   <= '0;
    end else begin
      tent_q <= tent_d;
      done_q <= done_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/usbrx_drain.sv
`timescale 1ns/1ps
module usbrx_drain #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              rd_valid,
  input  logic              mem_ready,
  output logic              rd_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign mem_we   = rd_valid;
  assign rd_en    = rd_valid && mem_ready;
  assign mem_addr = addr_q;

  always_comb begin
    addr_d = addr_q;
    if (load)       addr_d = load_addr;
    else if (rd_en) addr_d = addr_q + ADDR_W'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/usbrx_ctrl.sv
`timescale 1ns/1ps
module usbrx_ctrl
  import usbrx_pkg::*;
#(
  parameter int MPS_W  = 11,
  parameter int SIZE_W = 19,
  parameter int CNT_W  = 10,
  parameter int FW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [SIZE_W-1:0] arm_size,
  input  logic [CNT_W-1:0]  arm_count,
  input  logic [MPS_W-1:0]  cfg_mps,
  input  logic              tok_out,
  input  logic              pkt_start,
  input  logic              pkt_pid,
  input  logic              rx_eop,
  input  logic              rx_crc_ok,
  input  logic [MPS_W:0]    pkt_len,
  input  logic              babble,
  input  logic [FW-1:0]     free_words,
  output logic              take,
  output logic              commit,
  output logic              rewind,
  output logic              hs_valid,
  output logic              hs_ack,
  output logic              ep_enabled,
  output logic              ep_nak,
  output logic [SIZE_W-1:0] xfer_size,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              xfer_done
);
  localparam int LEN_W = MPS_W + 1;

  rx_mode_e          mode_q, mode_d;
  logic              en_q, en_d, nak_q, nak_d;
  logic              pid_q, pid_d, exp_q, exp_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hsv_q, hsv_d, hsa_q, hsa_d, done_q, done_d;

  logic [LEN_W-1:0]  mps_words, mps_round, stored;
  logic              room_ok, admit, eop_take, eop_refuse;
  logic              good, fresh, short_pkt, finish;

  assign mps_words  = (LEN_W'(cfg_mps) + LEN_W'(3)) >> 2;
  assign mps_round  = mps_words << 2;
  assign room_ok    = 32'(free_words) >= 32'(mps_words);
  assign admit      = en_q && !nak_q && room_ok;
  assign eop_take   = (mode_q == MODE_TAKE) && rx_eop;
  assign eop_refuse = (mode_q == MODE_REFUSE) && rx_eop;
  assign good       = rx_crc_ok && !babble;
  assign fresh      = pid_q == exp_q;
  assign commit     = eop_take && good && fresh;
  assign rewind     = eop_take && !(good && fresh);
  assign short_pkt  = pkt_len < LEN_W'(cfg_mps);
  assign stored     = short_pkt ? pkt_len : mps_round;
  assign finish     = commit && ((cnt_q == CNT_W'(1)) || short_pkt);
  assign take       = mode_q == MODE_TAKE;

  always_comb begin
    mode_d = mode_q;
    if (tok_out)     mode_d = admit ? MODE_TAKE : MODE_REFUSE;
    else if (rx_eop) mode_d = MODE_IDLE;

    pid_d  = pkt_start ? pkt_pid : pid_q;
    exp_d  = commit ? !exp_q : exp_q;

    en_d   = en_q;
    nak_d  = nak_q;
    size_d = size_q;
    cnt_d  = cnt_q;
    if (arm) begin
      en_d   = 1'b1;
      nak_d  = 1'b0;
      size_d = arm_size;
      cnt_d  = arm_count;
    end else if (commit) begin
      size_d = size_q - SIZE_W'(stored);
      cnt_d  = cnt_q - 1'b1;
      if (finish) begin
        en_d  = 1'b0;
        nak_d = 1'b1;
      end
    end

    hsv_d  = (eop_take && good) || (eop_refuse && rx_crc_ok);
    hsa_d  = eop_take;
    done_d = finish && !arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      en_q   <= 1'b0;
      nak_q  <= 1'b1;
      pid_q  <= 1'b0;
      exp_q  <= 1'b0;
      size_q <= '0;
      cnt_q  <= '0;
      hsv_q  <= 1'b0;
      hsa_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      nak_q  <= nak_d;
      pid_q  <= pid_d;
      exp_q  <= exp_d;
      size_q <= size_d;
      cnt_q  <= cnt_d;
      hsv_q  <= hsv_d;
      hsa_q  <= hsa_d;
      done_q <= done_d;
    end
  end

  assign hs_valid   = hsv_q;
  assign hs_ack     = hsa_q;
  assign ep_enabled = en_q;
  assign ep_nak     = nak_q;
  assign xfer_size  = size_q;
  assign pkt_count  = cnt_q;
  assign xfer_done  = done_q;
endmodule

// File: rtl/usb_out_ep_rx.sv
`timescale 1ns/1ps
module usb_out_ep_rx #(
  parameter int MPS_W      = 11,
  parameter int SIZE_W     = 19,
  parameter int CNT_W      = 10,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MPS_W-1:0]  cfg_mps,
  input  logic              arm,
  input  logic [SIZE_W-1:0] arm_size,
  input  logic [CNT_W-1:0]  arm_count,
  input  logic [ADDR_W-1:0] arm_base,
  input  logic              tok_out,
  input  logic              pkt_start,
  input  logic              pkt_pid,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eop,
  input  logic              rx_crc_ok,
  output logic              hs_valid,
  output logic              hs_ack,
  output logic              ep_enabled,
  output logic              ep_nak,
  output logic [SIZE_W-1:0] xfer_size,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              xfer_done,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int FW = $clog2(FIFO_DEPTH) + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             take, commit, rewind;
  logic             wr_en, babble, rd_en, rd_valid;
  logic [31:0]      wr_data;
  logic [MPS_W:0]   pkt_len;
  logic [FW-1:0]    free_words;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usbrx_packer #(.MPS_W(MPS_W)) u_packer (
    .clk(clk), .rst_n(rst_int_n), .take(take), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_eop(rx_eop), .cfg_mps(cfg_mps),
    .wr_en(wr_en), .wr_data(wr_data), .pkt_len(pkt_len), .babble(babble)
  );

  usbrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .commit(commit), .rewind(rewind), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(mem_wdata), .free_words(free_words)
  );

  usbrx_drain #(.ADDR_W(ADDR_W)) u_drain (
    .clk(clk), .rst_n(rst_int_n), .load(arm), .load_addr(arm_base),
    .rd_valid(rd_valid), .mem_ready(mem_ready), .rd_en(rd_en),
    .mem_we(mem_we), .mem_addr(mem_addr)
  );

  usbrx_ctrl #(.MPS_W(MPS_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .FW(FW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .arm(arm), .arm_size(arm_size),
    .arm_count(arm_count), .cfg_mps(cfg_mps), .tok_out(tok_out),
    .pkt_start(pkt_start), .pkt_pid(pkt_pid), .rx_eop(rx_eop),
    .rx_crc_ok(rx_crc_ok), .pkt_len(pkt_len), .babble(babble),
    .free_words(free_words), .take(take), .commit(commit), .rewind(rewind),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .ep_enabled(ep_enabled),
    .ep_nak(ep_nak), .xfer_size(xfer_size), .pkt_count(pkt_count),
    .xfer_done(xfer_done)
  );
endmodule

// File: rtl/usbrx_checker.sv
`timescale 1ns/1ps
module usbrx_checker #(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              rx_eop,
  input logic              hs_valid,
  input logic              hs_ack,
  input logic              ep_enabled,
  input logic              ep_nak,
  input logic [CNT_W-1:0]  pkt_count,
  input logic              xfer_done,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_HS_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(rx_eop)); // R10

  AST_NAK_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ack) |-> $stable(pkt_count)); // R2

  AST_COUNT_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(arm) && (pkt_count != $past(pkt_count))) |-> (pkt_count == $past(pkt_count) - 1'b1)); // R4

  AST_DONE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!ep_enabled && ep_nak)); // R9

  AST_DONE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (hs_valid && hs_ack)); // R9

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00)); // R8

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready && !arm) |=> $stable(mem_addr)); // R11
endmodule

bind usb_out_ep_rx usbrx_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .arm(arm), .rx_eop(rx_eop), .hs_valid(hs_valid),
  .hs_ack(hs_ack), .ep_enabled(ep_enabled), .ep_nak(ep_nak),
  .pkt_count(pkt_count), .xfer_done(xfer_done), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/usb_out_ep_rx_test.sv
`timescale 1ns/1ps
module usb_out_ep_rx_test;
  logic        clk;
  logic        rst_n;
  logic [10:0] cfg_mps;
  logic        arm;
  logic [18:0] arm_size;
  logic [9:0]  arm_count;
  logic [31:0] arm_base;
  logic        tok_out, pkt_start, pkt_pid, rx_valid, rx_eop, rx_crc_ok;
  logic [7:0]  rx_byte;
  logic        hs_valid, hs_ack, ep_enabled, ep_nak, xfer_done;
  logic [18:0] xfer_size;
  logic [9:0]  pkt_count;
  logic        mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  bit finished = 0;
  logic [31:0] cap [256];
  logic hs_seen, ack_seen, done_seen;

  usb_out_ep_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_mps(cfg_mps), .arm(arm),
    .arm_size(arm_size), .arm_count(arm_count), .arm_base(arm_base),
    .tok_out(tok_out), .pkt_start(pkt_start), .pkt_pid(pkt_pid),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .rx_crc_ok(rx_crc_ok), .hs_valid(hs_valid), .hs_ack(hs_ack),
    .ep_enabled(ep_enabled), .ep_nak(ep_nak), .xfer_size(xfer_size),
    .pkt_count(pkt_count), .xfer_done(xfer_done), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && mem_we && mem_ready) begin
      cap[mem_addr[9:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_arm(input logic [18:0] sz, input logic [9:0] cnt, input logic [31:0] base);
    @(negedge clk);
    arm = 1'b1; arm_size = sz; arm_count = cnt; arm_base = base;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic send_pkt(input logic pid, input int len, input logic crc, input logic [7:0] b0);
    @(negedge clk);
    tok_out = 1'b1;
    @(negedge clk);
    tok_out = 1'b0; pkt_start = 1'b1; pkt_pid = pid;
    @(negedge clk);
    pkt_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_byte = b0 + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eop = 1'b1; rx_crc_ok = crc;
    @(negedge clk);
    rx_eop = 1'b0; rx_crc_ok = 1'b0;
    hs_seen = hs_valid; ack_seen = hs_ack; done_seen = xfer_done;
    @(negedge clk);
    chk("R10 handshake is a single pulse", {63'd0, hs_valid}, 64'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset enabled", {63'd0, ep_enabled}, 64'd0);
    chk("R1 reset nak", {63'd0, ep_nak}, 64'd1);
    chk("R1 reset count", {54'd0, pkt_count}, 64'd0);
    chk("R1 reset size", {45'd0, xfer_size}, 64'd0);
  endtask

  task automatic t_first();
    do_arm(19'd48, 10'd4, 32'h100);
    chk("R1 arm enables", {63'd0, ep_enabled}, 64'd1);
    chk("R1 arm clears nak", {63'd0, ep_nak}, 64'd0);
    chk("R1 arm loads count", {54'd0, pkt_count}, 64'd4);
    send_pkt(1'b0, 10, 1'b1, 8'h00);
    chk("R4 R12 DATA0 first is ACKed", {62'd0, hs_seen, ack_seen}, 64'd3);
    chk("R4 count after full packet", {54'd0, pkt_count}, 64'd3);
    chk("R4 size drops by rounded mps", {45'd0, xfer_size}, 64'd36);
    idle(6);
    chk("R8 word0 lanes", {32'd0, cap[64]}, 64'h03020100);
    chk("R8 word1 lanes", {32'd0, cap[65]}, 64'h07060504);
    chk("R8 pad lanes zero", {32'd0, cap[66]}, 64'h00000908);
    chk("R8 three words written", wr_cnt, 64'd3);
  endtask

  task automatic t_dup();
    send_pkt(1'b0, 10, 1'b1, 8'h90);
    chk("R5 retransmit ACKed", {62'd0, hs_seen, ack_seen}, 64'd3);
    chk("R5 count unchanged", {54'd0, pkt_count}, 64'd3);
    chk("R5 size unchanged", {45'd0, xfer_size}, 64'd36);
    idle(6);
    chk("R5 nothing written", wr_cnt, 64'd3);
  endtask

  task automatic t_badcrc();
    send_pkt(1'b1, 10, 1'b0, 8'hA0);
    chk("R6 no handshake on bad crc", {63'd0, hs_seen}, 64'd0);
    chk("R6 count unchanged", {54'd0, pkt_count}, 64'd3);
    idle(6);
    chk("R6 nothing written", wr_cnt, 64'd3);
  endtask

  task automatic t_babble();
    send_pkt(1'b1, 11, 1'b1, 8'hB0);
    chk("R7 no handshake on oversize", {63'd0, hs_seen}, 64'd0);
    chk("R7 count unchanged", {54'd0, pkt_count}, 64'd3);
    idle(6);
    chk("R7 nothing written", wr_cnt, 64'd3);
  endtask

  task automatic t_second();
    send_pkt(1'b1, 10, 1'b1, 8'h20);
    chk("R12 DATA1 accepted after toggle", {62'd0, hs_seen, ack_seen}, 64'd3);
    chk("R4 count", {54'd0, pkt_count}, 64'd2);
    chk("R4 size", {45'd0, xfer_size}, 64'd24);
    chk("R9 no done on full packet", {63'd0, done_seen}, 64'd0);
    idle(6);
    chk("R8 next packet on next word", {32'd0, cap[67]}, 64'h23222120);
    chk("R8 padded last word", {32'd0, cap[69]}, 64'h00002928);
  endtask

  task automatic t_short();
    send_pkt(1'b0, 5, 1'b1, 8'h40);
    chk("R9 short packet ACKed", {62'd0, hs_seen, ack_seen}, 64'd3);
    chk("R9 done pulse", {63'd0, done_seen}, 64'd1);
    chk("R4 count after short", {54'd0, pkt_count}, 64'd1);
    chk("R4 size drops by length", {45'd0, xfer_size}, 64'd19);
    chk("R9 disabled", {63'd0, ep_enabled}, 64'd0);
    chk("R9 nak set", {63'd0, ep_nak}, 64'd1);
    idle(6);
    chk("R8 short word0", {32'd0, cap[70]}, 64'h43424140);
    chk("R8 short tail", {32'd0, cap[71]}, 64'h00000044);
  endtask

  task automatic t_disabled();
    send_pkt(1'b1, 10, 1'b1, 8'hC0);
    chk("R2 NAK while disabled", {62'd0, hs_seen, ack_seen}, 64'd2);
    chk("R2 count unchanged", {54'd0, pkt_count}, 64'd1);
    idle(6);
    chk("R2 nothing written", wr_cnt, 64'd8);
  endtask

  task automatic t_full();
    logic p;
    mem_ready = 1'b0;
    do_arm(19'd120, 10'd10, 32'h200);
    p = 1'b1;
    for (int k = 0; k < 5; k++) begin
      send_pkt(p, 10, 1'b1, 8'h50 + 8'(16 * k));
      chk("R3 packet fits", {62'd0, hs_seen, ack_seen}, 64'd3);
      p = ~p;
    end
    chk("R4 count after five", {54'd0, pkt_count}, 64'd5);
    send_pkt(p, 10, 1'b1, 8'hF0);
    chk("R3 NAK when room short", {62'd0, hs_seen, ack_seen}, 64'd2);
    chk("R3 count unchanged", {54'd0, pkt_count}, 64'd5);
    chk("R11 stalled address held", {32'd0, mem_addr}, 64'h200);
    chk("R11 no write while stalled", wr_cnt, 64'd8);
    mem_ready = 1'b1;
    idle(30);
    chk("R11 drained after ready", wr_cnt, 64'd23);
    chk("R11 address advanced", {32'd0, mem_addr}, 64'h23C);
    chk("R8 first word at new base", {32'd0, cap[128]}, 64'h53525150);
    chk("R8 last word of fifth", {32'd0, cap[142]}, 64'h00009998);
    send_pkt(p, 10, 1'b1, 8'hF0);
    chk("R3 retry ACKed", {62'd0, hs_seen, ack_seen}, 64'd3);
    chk("R3 retry counted", {54'd0, pkt_count}, 64'd4);
  endtask

  initial begin
    rst_n = 1'b0; cfg_mps = 11'd10; arm = 1'b0; arm_size = '0; arm_count = '0;
    arm_base = '0; tok_out = 1'b0; pkt_start = 1'b0; pkt_pid = 1'b0;
    rx_valid = 1'b0; rx_byte = '0; rx_eop = 1'b0; rx_crc_ok = 1'b0;
    mem_ready = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_first();
    t_dup();
    t_badcrc();
    t_babble();
    t_second();
    t_short();
    t_disabled();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule